// File: doc/BRIEF.md
# Address Compare Stop Unit

This unit watches the storage address register of a processor and compares it with a manually set 16-bit address switch value. The comparison is taken once per storage cycle, at the strobe that opens the cycle. A three-position compare switch selects the reaction to a hit:

- **Off** does nothing.
- **Run** emits a single-cycle sync pulse, which an instrument can trigger on.
- **Stop** emits the same pulse and also halts the processor.

A stop never cuts a storage read/write cycle short. The halt is held back until the cycle-complete strobe of the same cycle arrives. The processor then stays halted until the operator presses the start key.

While the processor is halted, storage cycles are ignored. I/O transfer requests keep flowing through the unit with a fixed one-cycle latency, so no I/O data is lost during the stop.

The controller is a four-state machine:

- **ST_IDLE**: no storage cycle open.
- **ST_CYCLE**: a cycle is open and no stop is armed.
- **ST_PEND**: a cycle is open and a stop is armed.
- **ST_HALT**: the processor is halted.

Its transitions are:

- *accept* (ST_IDLE to ST_CYCLE or ST_PEND, on the cycle-open strobe).
- *close* (ST_CYCLE to ST_IDLE, on the cycle-complete strobe).
- *cancel* (ST_PEND to ST_CYCLE, or to ST_IDLE if the cycle-complete strobe is also present, when the switch is moved to off).
- *stop* (ST_PEND to ST_HALT, on the cycle-complete strobe).
- *resume* (ST_HALT to ST_IDLE, on a start key press or when the switch is moved to off).

Top module: `acs_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sync_pulse`, `proc_halt` and `io_grant` are 0.
- R2: A hit means `sw_addr` equals `sar` in all 16 bits, sampled in the cycle where `cyc_start` is accepted in ST_IDLE. A difference in any single bit, the lowest or the highest, gives no hit.
- R3: With `cmp_mode` = 2'b01 (run), an accepted `cyc_start` with a hit raises `sync_pulse` for exactly one cycle, the cycle after the strobe. `proc_halt` stays 0.
- R4: With `cmp_mode` = 2'b10 (stop), a hit also raises `sync_pulse`. `proc_halt` stays 0 until `cyc_done` closes that storage cycle, and rises in the cycle after that `cyc_done`.
- R5: Once `proc_halt` is 1, it stays 1 until a rising edge of `start_key` is sampled, and goes to 0 in the next cycle. Holding the key down does not repeat the release.
- R6: Exactly one compare is made per storage cycle. A further `cyc_start` before `cyc_done` is ignored, and `cyc_start` and `cyc_done` are ignored while halted, including in the cycle where the halt is released.
- R7: `io_grant` equals `io_req` delayed by one clock in every state, including while halted.
- R8: In off position (`cmp_mode` 2'b00 or 2'b11), neither `sync_pulse` nor `proc_halt` is ever raised. Moving the switch to off cancels an armed stop, and it releases an existing halt in the next cycle.
- R9: A stop armed in stop position is still carried out if the switch is moved to run before `cyc_done`. Only off cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_mode | input | 2 | Compare switch: 00 off, 01 run, 10 stop, 11 off |
| sw_addr | input | 16 | Address switch setting |
| sar | input | 16 | Storage address register value |
| cyc_start | input | 1 | Storage cycle open strobe |
| cyc_done | input | 1 | Storage cycle complete strobe |
| start_key | input | 1 | Start key level |
| io_req | input | 1 | I/O transfer request |
| sync_pulse | output | 1 | One-cycle hit pulse |
| proc_halt | output | 1 | Processor halt |
| io_grant | output | 1 | I/O transfer pass-through |

## Verification
The compare is tried with equal addresses, with addresses that differ only in bit 0 or only in bit 15, and with a random stream drawn from a narrow address range so that hits and misses mix. Together these show that a full-width compare is made, and that it is taken only at cycle open. Storage cycles of different lengths, with I/O toggling and the start key held or pulsed, show that the halt waits for cycle completion and that resume is edge-triggered. Moving the switch to run, stop or off in the middle of a cycle or during a halt tells apart the switch value latched at the hit from the live switch value.

// File: rtl/acs_pkg.sv
package acs_pkg;

    typedef enum logic [1:0] {
        SW_OFF     = 2'b00,
        SW_RUN     = 2'b01,
        SW_STOP    = 2'b10,
        SW_OFF_ALT = 2'b11
    } acs_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CYCLE,
        ST_PEND,
        ST_HALT
    } acs_state_e;

    function automatic logic mode_is_off(input logic [1:0] m);
        return (m == SW_OFF) || (m == SW_OFF_ALT);
    endfunction

endpackage

// File: rtl/acs_addr_cmp.sv
module acs_addr_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] a_in,
    input  logic [ADDR_W-1:0] b_in,
    output logic              equal
);
    logic [ADDR_W-1:0] bit_diff;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_diff[i] = a_in[i] ^ b_in[i];
    end

    assign equal = ~|bit_diff;
endmodule

// File: rtl/acs_key_edge.sv
module acs_key_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic key,
    output logic press
);
    logic key_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= 1'b0;
        else        key_q <= key;
    end

    assign press = key & ~key_q;
endmodule

// File: rtl/acs_io_pass.sv
module acs_io_pass #(
    parameter int IO_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] req,
    output logic [IO_W-1:0] grant
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant <= '0;
        else        grant <= req;
    end
endmodule

// File: rtl/acs_ctrl_fsm.sv
module acs_ctrl_fsm
    import acs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       hit,
    input  logic       cyc_start,
    input  logic       cyc_done,
    input  logic       key_press,
    output logic       sync_q,
    output logic       halt_q
);
    acs_state_e state, state_nxt;
    logic       off_now;
    logic       stop_now;
    logic       sync_nxt;

    assign off_now  = mode_is_off(mode);
    assign stop_now = (mode == SW_STOP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        sync_nxt  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cyc_start) begin
                    sync_nxt  = hit && !off_now;
                    state_nxt = (hit && stop_now) ? ST_PEND : ST_CYCLE;
                end
            end
            ST_CYCLE: begin
                if (cyc_done) state_nxt = ST_IDLE;
            end
            ST_PEND: begin
                if (off_now)       state_nxt = cyc_done ? ST_IDLE : ST_CYCLE;
                else if (cyc_done) state_nxt = ST_HALT;
            end
            ST_HALT: begin
                if (key_press || off_now) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            sync_q <= sync_nxt;
            halt_q <= (state_nxt == ST_HALT);
        end
    end
endmodule

// File: rtl/acs_unit.sv
module acs_unit
    import acs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmp_mode,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [ADDR_W-1:0] sar,
    input  logic              cyc_start,
    input  logic              cyc_done,
    input  logic              start_key,
    input  logic              io_req,
    output logic              sync_pulse,
    output logic              proc_halt,
    output logic              io_grant
);
    logic hit;
    logic key_press;

    acs_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .a_in  (sw_addr),
        .b_in  (sar),
        .equal (hit)
    );

    acs_key_edge u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .key   (start_key),
        .press (key_press)
    );

    acs_io_pass #(.IO_W(1)) u_io (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (io_req),
        .grant (io_grant)
    );

    acs_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cmp_mode),
        .hit       (hit),
        .cyc_start (cyc_start),
        .cyc_done  (cyc_done),
        .key_press (key_press),
        .sync_q    (sync_pulse),
        .halt_q    (proc_halt)
    );
endmodule

// File: rtl/acs_unit_chk.sv
module acs_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmp_mode,
    input logic [ADDR_W-1:0] sw_addr,
    input logic [ADDR_W-1:0] sar,
    input logic              cyc_start,
    input logic              cyc_done,
    input logic              start_key,
    input logic              io_req,
    input logic              sync_pulse,
    input logic              proc_halt,
    input logic              io_grant
);
    // R2: a sync pulse needs an equal address at an open strobe
    a_r2_sync_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> ($past(sw_addr == sar) && $past(cyc_start)));

    // R3: sync lasts a single cycle
    a_r3_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    // R4: halt only rises right after a cycle-complete strobe
    a_r4_halt_at_cycle_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_halt) |-> $past(cyc_done));

    // R5: halt release only on key edge or switch off
    a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(proc_halt) |-> (($past(start_key) && !$past(start_key, 2))
                              || $past(cmp_mode) == 2'b00 || $past(cmp_mode) == 2'b11));

    // R6: no compare accepted while halted
    a_r6_no_sync_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        proc_halt |=> !sync_pulse);

    // R7: I/O passes with one cycle latency
    a_r7_io_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (io_grant == $past(io_req)));

    // R8: no sync when the switch was off
    a_r8_off_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> ($past(cmp_mode) == 2'b01 || $past(cmp_mode) == 2'b10));

    // R8: no halt entered while off
    a_r8_off_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_halt) |-> ($past(cmp_mode) == 2'b01 || $past(cmp_mode) == 2'b10));
endmodule

bind acs_unit acs_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_mode   (cmp_mode),
    .sw_addr    (sw_addr),
    .sar        (sar),
    .cyc_start  (cyc_start),
    .cyc_done   (cyc_done),
    .start_key  (start_key),
    .io_req     (io_req),
    .sync_pulse (sync_pulse),
    .proc_halt  (proc_halt),
    .io_grant   (io_grant)
);

// File: tb/acs_unit_tb.sv
`timescale 1ns/1ps
module acs_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmp_mode = 2'b00;
    logic [15:0] sw_addr = 16'h0;
    logic [15:0] sar = 16'h0;
    logic        cyc_start = 1'b0;
    logic        cyc_done = 1'b0;
    logic        start_key = 1'b0;
    logic        io_req = 1'b0;
    logic        sync_pulse, proc_halt, io_grant;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    done_flag = 0;
    string tag = "R1";

    // reference model state
    bit m_halted = 0, m_incyc = 0, m_pend = 0, m_prev_key = 0;
    bit e_sync = 0, e_halt = 0, e_io = 0;

    always #2.5 clk = ~clk;

    acs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .sw_addr(sw_addr), .sar(sar),
        .cyc_start(cyc_start), .cyc_done(cyc_done), .start_key(start_key), .io_req(io_req),
        .sync_pulse(sync_pulse), .proc_halt(proc_halt), .io_grant(io_grant)
    );

    // behavioural model, one step per rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_halted = 0; m_incyc = 0; m_pend = 0; m_prev_key = 0;
            e_sync = 0; e_halt = 0; e_io = 0;
        end else begin
            bit press, off;
            press = start_key && !m_prev_key;
            m_prev_key = start_key;
            off = (cmp_mode == 2'b00) || (cmp_mode == 2'b11);
            e_io = io_req;
            e_sync = 0;
            if (m_halted) begin
                if (press || off) m_halted = 0;
            end else if (!m_incyc) begin
                if (cyc_start) begin
                    m_incyc = 1;
                    e_sync = (sw_addr == sar) && !off;
                    m_pend = (sw_addr == sar) && (cmp_mode == 2'b10);
                end
            end else begin
                if (off) m_pend = 0;
                if (cyc_done) begin
                    m_incyc = 0;
                    if (m_pend) m_halted = 1;
                    m_pend = 0;
                end
            end
            e_halt = m_halted;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done_flag) begin
            vectors++;
            if (sync_pulse !== e_sync) begin
                miscompares++;
                $display("FAIL %s sync_pulse act=%0b exp=%0b t=%0t", tag, sync_pulse, e_sync, $time);
            end
            if (proc_halt !== e_halt) begin
                miscompares++;
                $display("FAIL %s proc_halt act=%0b exp=%0b t=%0t", tag, proc_halt, e_halt, $time);
            end
            if (io_grant !== e_io) begin
                miscompares++;
                $display("FAIL R7 io_grant act=%0b exp=%0b t=%0t", io_grant, e_io, $time);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done_flag) begin
            done_flag = 1;
            miscompares++;
            $display("FAIL watchdog expired act=%0d expected<=50000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); cyc_start = 1;
        @(negedge clk); cyc_start = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); cyc_done = 1;
        @(negedge clk); cyc_done = 0;
    endtask

    task automatic press_key();
        @(negedge clk); start_key = 1;
        @(negedge clk); start_key = 0;
    endtask

    task automatic storage_cycle(input int len);
        pulse_start();
        wait_n(len);
        pulse_done();
        wait_n(2);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        wait_n(4);
        @(negedge clk); rst_n = 1;
        wait_n(2);

        // R7: I/O pattern outside any cycle
        tag = "R7";
        for (int i = 0; i < 8; i++) begin @(negedge clk); io_req = i[0] ^ i[2]; end
        io_req = 0;

        // R3: run position hit
        tag = "R3";
        cmp_mode = 2'b01; sw_addr = 16'h1234; sar = 16'h1234;
        storage_cycle(3);

        // R2: single-bit differences
        tag = "R2";
        sar = 16'h1235; storage_cycle(2);
        sar = 16'h9234; storage_cycle(2);
        sar = 16'h1234; storage_cycle(1);

        // R4: stop position, long cycle, I/O during halt (R7)
        tag = "R4";
        cmp_mode = 2'b10; sw_addr = 16'hBEEF; sar = 16'hBEEF;
        pulse_start(); wait_n(6); pulse_done();
        tag = "R7";
        for (int i = 0; i < 6; i++) begin @(negedge clk); io_req = ~io_req; end
        io_req = 0;

        // R6: strobes ignored during halt
        tag = "R6";
        pulse_start(); wait_n(1); pulse_done(); wait_n(2);

        // R5: held key releases once, then re-halt and press again
        tag = "R5";
        @(negedge clk); start_key = 1; wait_n(5);
        @(negedge clk); start_key = 0;
        storage_cycle(2);
        wait_n(3);
        press_key(); wait_n(3);

        // R6: release cycle coincides with a cycle strobe
        tag = "R6";
        storage_cycle(1);
        @(negedge clk); start_key = 1; cyc_start = 1;
        @(negedge clk); start_key = 0; cyc_start = 0;
        wait_n(2);
        // R6: second open strobe inside one cycle
        sar = 16'h0001;
        pulse_start(); sar = 16'hBEEF; pulse_start(); wait_n(1); pulse_done(); wait_n(2);

        // R9: stop armed, switch moved to run before completion
        tag = "R9";
        pulse_start(); cmp_mode = 2'b01; wait_n(2); pulse_done(); wait_n(2);
        press_key(); wait_n(2);

        // R8: off positions with a hit
        tag = "R8";
        cmp_mode = 2'b00; storage_cycle(2);
        cmp_mode = 2'b11; storage_cycle(2);
        // R8: cancel armed stop
        cmp_mode = 2'b10; pulse_start(); cmp_mode = 2'b00; wait_n(2); pulse_done(); wait_n(2);
        // R8: off releases a halt
        cmp_mode = 2'b10; storage_cycle(1); wait_n(2);
        cmp_mode = 2'b11; wait_n(3);

        // R2: mixed random stream, narrow address range
        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            cyc_start = ($urandom_range(0, 3) == 0);
            cyc_done  = ($urandom_range(0, 3) == 0);
            start_key = ($urandom_range(0, 5) == 0);
            io_req    = $urandom_range(0, 1) == 1;
            sar       = 16'(32'hA000 + $urandom_range(0, 2));
            sw_addr   = 16'hA001;
            if ($urandom_range(0, 31) == 0) cmp_mode = 2'($urandom_range(0, 3));
        end
        cyc_start = 0; cyc_done = 0; start_key = 0; io_req = 0;
        wait_n(3);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule